// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit for a multicycle 32-bit RISC datapath. Each instruction takes several clock cycles. The block moves through a fixed chain of steps and drives a fixed set of multiplexer selects and write strobes in each step. All instructions share the first two steps:

- **Fetch:** the instruction word is loaded and the program counter advances by four.
- **Decode / register fetch:** a branch target is precomputed.

After decode, the 6-bit opcode held in the instruction register chooses one of two paths:

- **Register-register arithmetic:** execute, then register write.
- **Word load:** address calculation, memory read, then register write.

Every other opcode returns to fetch without side effects.

The outputs are a pure function of the current step, so the datapath sees steady strobes for the whole cycle. Any strobe that a step does not name is held at 0. The datapath, the memory and the ALU function decoder are outside this block. The opcode is examined only in the decode step.

Top module: `mcycle_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in the fetch step. While reset is held, and in the first cycle after it, the outputs show the fetch vector.
- R2: In fetch the outputs are memAddrSel=0, memRead=1, irLoad=1, pcLoad=1, pcSel=01, aluASel=0, aluBSel=01, aluMode=00 (ALU adds), and every other output is 0.
- R3: The cycle after fetch is decode. In decode the outputs are aluASel=0, aluBSel=11 (shifted sign-extended offset), aluMode=00, and every other output is 0.
- R4: If the opcode in decode is 000000, the next step is arithmetic execute: aluASel=1, aluBSel=00, aluMode=10 (operation from the function field), and every other output is 0.
- R5: After arithmetic execute comes arithmetic write: regWrite=1, regDataSel=0 (ALU result), regDestSel=1 (rd field), and every other output is 0. The step after it is fetch.
- R6: If the opcode in decode is 100011, the next step is load address: aluASel=1, aluBSel=10 (sign-extended offset), aluMode=00, and every other output is 0.
- R7: After load address comes load memory: memAddrSel=1 (ALU result as address), memRead=1, and every other output is 0.
- R8: After load memory comes load write: regWrite=1, regDataSel=1 (memory data), regDestSel=0 (rt field), and every other output is 0. The step after it is fetch.
- R9: Any opcode in decode other than 000000 or 100011 makes the next step fetch.
- R10: The opcode has no effect in any step other than decode.
- R11: regWrite and memRead are never 1 in the same cycle, and pcLoad is 1 only together with irLoad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| memAddrSel | output | 1 | Memory address select: 0 = PC, 1 = ALU result register |
| memRead | output | 1 | Memory read strobe |
| irLoad | output | 1 | Instruction register write enable |
| pcLoad | output | 1 | Program counter write enable |
| pcSel | output | 2 | Program counter source select |
| aluMode | output | 2 | ALU operation class: 00 add, 10 from function field |
| aluASel | output | 1 | ALU A input: 0 = PC, 1 = register A |
| aluBSel | output | 2 | ALU B input: 00 reg B, 01 constant 4, 10 offset, 11 offset shifted by 2 |
| regWrite | output | 1 | Register file write enable |
| regDataSel | output | 1 | Register write data: 0 = ALU result, 1 = memory data |
| regDestSel | output | 1 | Destination register: 0 = rt, 1 = rd |

## Verification
The assertions check on every cycle:
- the step-to-step ordering that can be seen from the strobes: fetch is followed by decode; each opcode class in decode leads to its own next step; each write step returns to fetch;
- the rule that register writes and memory reads never overlap;
- the rule that the program counter is loaded only together with the instruction register.

Only the bench scenarios can show that each step's whole vector is exact, with every unnamed strobe held at 0. The same holds for four other behaviours:
- opcodes close to the two legal codes are rejected;
- a reset in the middle of a load abandons it;
- opcode changes outside decode leave the sequence unchanged;
- long random instruction streams stay in step with an independent model.

// File: rtl/mcycle_ctrl_pkg.sv
package mcycle_ctrl_pkg;

  localparam int SEL_W = 2;

  // Encodings of the two-bit selects seen by the datapath
  localparam logic [SEL_W-1:0] PC_FROM_ALU   = 2'b01;
  localparam logic [SEL_W-1:0] ALU_ADD       = 2'b00;
  localparam logic [SEL_W-1:0] ALU_FUNCT     = 2'b10;
  localparam logic [SEL_W-1:0] B_FROM_REG    = 2'b00;
  localparam logic [SEL_W-1:0] B_FOUR        = 2'b01;
  localparam logic [SEL_W-1:0] B_OFFSET      = 2'b10;
  localparam logic [SEL_W-1:0] B_OFFSET_SHL2 = 2'b11;

  typedef enum logic [2:0] {
    ST_FETCH   = 3'd0,
    ST_DECODE  = 3'd1,
    ST_ARITH   = 3'd2,
    ST_ARITHWB = 3'd3,
    ST_LDADDR  = 3'd4,
    ST_LDMEM   = 3'd5,
    ST_LDWB    = 3'd6
  } stepT;

  typedef struct packed {
    logic             memAddrSel;
    logic             memRead;
    logic             irLoad;
    logic             pcLoad;
    logic [SEL_W-1:0] pcSel;
    logic [SEL_W-1:0] aluMode;
    logic             aluASel;
    logic [SEL_W-1:0] aluBSel;
    logic             regWrite;
    logic             regDataSel;
    logic             regDestSel;
  } ctrlStrobesT;

endpackage

// File: rtl/mcycle_ctrl_seq.sv
module mcycle_ctrl_seq
  import mcycle_ctrl_pkg::*;
#(
  parameter int              OP_W    = 6,
  parameter logic [OP_W-1:0] OP_ARITH = '0,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'b100011
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  output stepT            curStep
);

  stepT nextStep;

  // The opcode is consulted only while decoding
  always_comb begin
    unique case (curStep)
      ST_FETCH:   nextStep = ST_DECODE;
      ST_DECODE: begin
        if (opcode == OP_ARITH)     nextStep = ST_ARITH;
        else if (opcode == OP_LOAD) nextStep = ST_LDADDR;
        else                        nextStep = ST_FETCH;
      end
      ST_ARITH:   nextStep = ST_ARITHWB;
      ST_ARITHWB: nextStep = ST_FETCH;
      ST_LDADDR:  nextStep = ST_LDMEM;
      ST_LDMEM:   nextStep = ST_LDWB;
      ST_LDWB:    nextStep = ST_FETCH;
      default:    nextStep = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curStep <= ST_FETCH;
    else     curStep <= nextStep;
  end

endmodule

// File: rtl/mcycle_ctrl_dec.sv
module mcycle_ctrl_dec
  import mcycle_ctrl_pkg::*;
(
  input  stepT        curStep,
  output ctrlStrobesT strobes
);

  always_comb begin
    strobes = '0;
    unique case (curStep)
      ST_FETCH: begin
        strobes.memRead = 1'b1;
        strobes.irLoad  = 1'b1;
        strobes.pcLoad  = 1'b1;
        strobes.pcSel   = PC_FROM_ALU;
        strobes.aluMode = ALU_ADD;
        strobes.aluBSel = B_FOUR;
      end
      ST_DECODE: begin
        strobes.aluMode = ALU_ADD;
        strobes.aluBSel = B_OFFSET_SHL2;
      end
      ST_ARITH: begin
        strobes.aluASel = 1'b1;
        strobes.aluBSel = B_FROM_REG;
        strobes.aluMode = ALU_FUNCT;
      end
      ST_ARITHWB: begin
        strobes.regWrite   = 1'b1;
        strobes.regDestSel = 1'b1;
      end
      ST_LDADDR: begin
        strobes.aluASel = 1'b1;
        strobes.aluBSel = B_OFFSET;
        strobes.aluMode = ALU_ADD;
      end
      ST_LDMEM: begin
        strobes.memAddrSel = 1'b1;
        strobes.memRead    = 1'b1;
      end
      ST_LDWB: begin
        strobes.regWrite   = 1'b1;
        strobes.regDataSel = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/mcycle_ctrl.sv
module mcycle_ctrl
  import mcycle_ctrl_pkg::*;
#(
  parameter int              OP_W    = 6,
  parameter logic [OP_W-1:0] OP_ARITH = '0,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'b100011
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opcode,
  output logic             memAddrSel,
  output logic             memRead,
  output logic             irLoad,
  output logic             pcLoad,
  output logic [SEL_W-1:0] pcSel,
  output logic [SEL_W-1:0] aluMode,
  output logic             aluASel,
  output logic [SEL_W-1:0] aluBSel,
  output logic             regWrite,
  output logic             regDataSel,
  output logic             regDestSel
);

  stepT        curStep;
  ctrlStrobesT strobes;

  mcycle_ctrl_seq #(
    .OP_W(OP_W), .OP_ARITH(OP_ARITH), .OP_LOAD(OP_LOAD)
  ) seqInst (
    .clk(clk), .rst(rst), .opcode(opcode), .curStep(curStep)
  );

  mcycle_ctrl_dec decInst (
    .curStep(curStep), .strobes(strobes)
  );

  assign memAddrSel = strobes.memAddrSel;
  assign memRead    = strobes.memRead;
  assign irLoad     = strobes.irLoad;
  assign pcLoad     = strobes.pcLoad;
  assign pcSel      = strobes.pcSel;
  assign aluMode    = strobes.aluMode;
  assign aluASel    = strobes.aluASel;
  assign aluBSel    = strobes.aluBSel;
  assign regWrite   = strobes.regWrite;
  assign regDataSel = strobes.regDataSel;
  assign regDestSel = strobes.regDestSel;

endmodule

// File: rtl/mcycle_ctrl_chk.sv
module mcycle_ctrl_chk #(
  parameter int              OP_W    = 6,
  parameter logic [OP_W-1:0] OP_ARITH = '0,
  parameter logic [OP_W-1:0] OP_LOAD  = 6'b100011
) (
  input logic            clk,
  input logic            rst,
  input logic [OP_W-1:0] opcode,
  input logic            memAddrSel,
  input logic            memRead,
  input logic            irLoad,
  input logic            pcLoad,
  input logic [1:0]      aluMode,
  input logic            aluASel,
  input logic [1:0]      aluBSel,
  input logic            regWrite,
  input logic            regDataSel
);

  logic inDecode;
  assign inDecode = (aluBSel == 2'b11) && !aluASel;

  // R1
  reset_to_fetch_chk: assert property (@(posedge clk) rst |=> pcLoad);

  // R3
  fetch_then_decode_chk: assert property (@(posedge clk) disable iff (rst)
    pcLoad |=> inDecode && !memRead && !regWrite);

  // R4
  arith_branch_chk: assert property (@(posedge clk) disable iff (rst)
    (inDecode && opcode == OP_ARITH) |=> aluASel && aluMode == 2'b10);

  // R6
  load_branch_chk: assert property (@(posedge clk) disable iff (rst)
    (inDecode && opcode == OP_LOAD) |=> aluASel && aluBSel == 2'b10);

  // R7
  load_mem_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (aluASel && aluBSel == 2'b10) |=> memAddrSel && memRead);

  // R8
  load_wb_follow_chk: assert property (@(posedge clk) disable iff (rst)
    memAddrSel |=> regWrite && regDataSel);

  // R9
  illegal_return_chk: assert property (@(posedge clk) disable iff (rst)
    (inDecode && opcode != OP_ARITH && opcode != OP_LOAD) |=> pcLoad);

  // R5
  wb_return_chk: assert property (@(posedge clk) disable iff (rst)
    regWrite |=> pcLoad);

  // R11
  no_write_read_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(regWrite && memRead));

  // R11
  pc_with_ir_chk: assert property (@(posedge clk) disable iff (rst)
    pcLoad |-> irLoad);

endmodule

bind mcycle_ctrl mcycle_ctrl_chk #(
  .OP_W(OP_W), .OP_ARITH(OP_ARITH), .OP_LOAD(OP_LOAD)
) chkInst (
  .clk(clk), .rst(rst), .opcode(opcode),
  .memAddrSel(memAddrSel), .memRead(memRead), .irLoad(irLoad),
  .pcLoad(pcLoad), .aluMode(aluMode), .aluASel(aluASel),
  .aluBSel(aluBSel), .regWrite(regWrite), .regDataSel(regDataSel)
);

// File: tb/mcycle_ctrl_test.sv
`timescale 1ns/1ps
module mcycle_ctrl_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic       memAddrSel, memRead, irLoad, pcLoad, aluASel;
  logic       regWrite, regDataSel, regDestSel;
  logic [1:0] pcSel, aluMode, aluBSel;

  int checks = 0;
  int failures = 0;
  int modelSt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mcycle_ctrl uut (
    .clk(clk), .rst(rst), .opcode(opcode),
    .memAddrSel(memAddrSel), .memRead(memRead), .irLoad(irLoad),
    .pcLoad(pcLoad), .pcSel(pcSel), .aluMode(aluMode), .aluASel(aluASel),
    .aluBSel(aluBSel), .regWrite(regWrite), .regDataSel(regDataSel),
    .regDestSel(regDestSel)
  );

  // steps: 0 fetch, 1 decode, 2 arith exec, 3 arith write,
  //        4 load addr, 5 load mem, 6 load write
  function automatic logic [13:0] expVec(int st);
    // {memAddrSel,memRead,irLoad,pcLoad,pcSel,aluMode,aluASel,aluBSel,regWrite,regDataSel,regDestSel}
    case (st)
      0: return {1'b0,1'b1,1'b1,1'b1,2'b01,2'b00,1'b0,2'b01,1'b0,1'b0,1'b0};
      1: return {1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b11,1'b0,1'b0,1'b0};
      2: return {1'b0,1'b0,1'b0,1'b0,2'b00,2'b10,1'b1,2'b00,1'b0,1'b0,1'b0};
      3: return {1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,1'b1,1'b0,1'b1};
      4: return {1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b1,2'b10,1'b0,1'b0,1'b0};
      5: return {1'b1,1'b1,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,1'b0,1'b0,1'b0};
      default: return {1'b0,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0,2'b00,1'b1,1'b1,1'b0};
    endcase
  endfunction

  function automatic int nextSt(int st, logic [5:0] op);
    case (st)
      0: return 1;
      1: return (op == 6'b000000) ? 2 : (op == 6'b100011) ? 4 : 0;
      2: return 3;
      4: return 5;
      5: return 6;
      default: return 0;
    endcase
  endfunction

  function automatic string stTag(int st);
    case (st)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic checkNow(string tag);
    logic [13:0] act;
    logic [13:0] exp;
    act = {memAddrSel, memRead, irLoad, pcLoad, pcSel, aluMode, aluASel,
           aluBSel, regWrite, regDataSel, regDestSel};
    exp = expVec(modelSt);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s step=%0d actual=%b expected=%b",
               (tag == "") ? stTag(modelSt) : tag, modelSt, act, exp);
    end
    checks++;
    if (regWrite && memRead) begin
      failures++;
      $display("FAIL R11 overlap actual=%b%b expected=not both", regWrite, memRead);
    end
  endtask

  // Apply inputs for one edge, then check at the following falling edge
  task automatic step(logic [5:0] op, logic r, string tag);
    int nxt;
    opcode = op;
    rst = r;
    nxt = r ? 0 : nextSt(modelSt, op);
    @(posedge clk);
    modelSt = nxt;
    @(negedge clk);
    checkNow(tag);
  endtask

  function automatic logic [5:0] pickOp();
    int sel;
    sel = $urandom_range(0, 9);
    if (sel < 4) return 6'b000000;
    if (sel < 8) return 6'b100011;
    return 6'($urandom_range(0, 63));
  endfunction

  initial begin
    int wd;
    for (wd = 0; wd < 100000; wd++) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(posedge clk);
    modelSt = 0;
    @(negedge clk);
    checkNow("R1");
    step(6'b100011, 1'b1, "R1");
    step(6'b111111, 1'b0, "R1");

    // arithmetic path
    step(6'b000000, 1'b0, "R3");
    step(6'b100011, 1'b0, "R4");
    step(6'b100011, 1'b0, "R5");
    step(6'b000000, 1'b0, "R5");
    // load path with opcode toggling outside decode
    step(6'b100011, 1'b0, "R3");
    step(6'b000000, 1'b0, "R6");
    step(6'b010101, 1'b0, "R10");
    step(6'b000000, 1'b0, "R10");
    step(6'b100011, 1'b0, "R8");
    // near-miss opcodes rejected
    step(6'b100010, 1'b0, "R3");
    step(6'b000001, 1'b0, "R9");
    step(6'b000001, 1'b0, "R3");
    step(6'b101011, 1'b0, "R9");
    step(6'b000100, 1'b0, "R3");
    // reset in the middle of a load
    step(6'b100011, 1'b0, "R3");
    step(6'b100011, 1'b0, "R6");
    step(6'b100011, 1'b0, "R7");
    step(6'b100011, 1'b1, "R1");
    step(6'b000000, 1'b0, "R3");

    for (int i = 0; i < 3000; i++) begin
      logic r;
      r = ($urandom_range(0, 199) == 0);
      step(pickOp(), r, r ? "R1" : "");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule